// File: doc/BRIEF.md
# Demand-Loaded Page Translation Unit

This block sits between an 8-bit CPU with a 16-bit address bus and a 21-bit physical memory space. The logical space is cut into 16 pages of 4 KiB, and each page is mapped to one of 512 physical frames. The block does not hold a full set of translations. It holds only a base pointer to the current task's mapping table, which lives in ordinary memory, plus a small cache with one slot per logical page.

When the CPU touches a page whose mapping is not cached, the block pulls the CPU's ready line low. It reads the page's 16-bit entry from the table as two byte reads on its own memory port, stores the entry, and then lets the CPU continue with the translated address. Each entry carries a valid flag, a write-protect flag and a no-execute flag. A write to a protected page, an opcode fetch from a no-execute page, or any access to an entry whose valid flag is clear latches a fault. The fault line goes high and the CPU stays stalled until a fault handler clears it through the register window.

The configuration registers sit in an 8-byte window at the top of the logical space. Accesses there are never translated and never stalled, so another agent driving the same bus can inspect and clear a fault. Writing either byte of the table base drops every cached mapping at once.

Top module: `demand_page_mmu`

## Requirements
- R1: After reset, fault is low, cpu_rdy is high while no access is presented, mem_req is low, the base, status and fault-address registers read 0, and no page is cached.
- R2: An access to a cached page that breaks no rule gets cpu_rdy high in the same cycle, with phys_addr = {frame[8:0], cpu_addr[11:0]} (21 bits).
- R3: An access to an uncached page drives cpu_rdy low at once. It then issues exactly two byte reads, low byte at base + 2*page and high byte at base + 2*page + 1, each held on mem_req/mem_addr until mem_ack. The entry word is {high, low}: bits 8:0 are the frame, bit 13 is write-protect, bit 14 is no-execute and bit 15 is valid.
- R4: Once a valid entry has been loaded, later accesses to that page cause no stall and no memory read.
- R5: A write to register offset 0 (base low byte) or offset 1 (base high byte) invalidates every cached entry, so the next access to any page refills.
- R6: A write to a page whose write-protect bit is set latches fault type 2. Reads of that page proceed normally.
- R7: An opcode fetch (cpu_fetch high) from a page whose no-execute bit is set latches fault type 3. Data reads of that page proceed normally.
- R8: An entry whose valid bit is clear is not cached and latches fault type 1. After the fault is cleared, an access to that page reads the table again.
- R9: A latched fault holds fault high and cpu_rdy low for every translated access until a write to offset 3 with bit 0 set. Offset 2 reads {pending, 0, type[1:0], 0000}. Offsets 4 and 5 read the faulting logical address, low and high byte.
- R10: Addresses 0xFFF8 to 0xFFFF form the register window. Accesses there are never stalled, never translated and start no table read, even while a fault is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU presents an access this cycle |
| cpu_addr | input | 16 | CPU logical address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_fetch | input | 1 | Access is an opcode fetch |
| cpu_wdata | input | 8 | Write data for the register window |
| cpu_rdata | output | 8 | Register window read data |
| cpu_rdy | output | 1 | Ready to the CPU; low stalls it |
| phys_addr | output | 21 | Translated physical address |
| fault | output | 1 | Latched protection or unmapped fault |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 21 | Table byte address |
| mem_rdata | input | 8 | Table read data |
| mem_ack | input | 1 | Table read completes this cycle |

## Verification
The assertions assume that the CPU keeps its address and access type steady while cpu_rdy is low. They also assume that the memory port answers only requests that are pending, and that the base registers are not written while a refill is in progress. The bench keeps inside these limits: it drives one access at a time, holds it until ready or a fault, and touches the register window only between accesses. Memory latency varies from cycle to cycle through a random acknowledge enable. The table contents and the base change only together with a base write, which keeps the bench's model of the cache exact.

// File: rtl/dpm_pkg.sv
// Shared encodings for the demand-loaded page translation unit.
// Assumes a 16-bit table entry word and an 8-byte register window.
package dpm_pkg;
    localparam int ENT_VALID_BIT = 15;
    localparam int ENT_NX_BIT    = 14;
    localparam int ENT_WP_BIT    = 13;

    typedef enum logic [1:0] {
        FT_NONE     = 2'd0,
        FT_UNMAPPED = 2'd1,
        FT_WPROT    = 2'd2,
        FT_NOEXEC   = 2'd3
    } fault_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2
    } seq_t;

    localparam logic [2:0] OFS_BASE_LO  = 3'd0;
    localparam logic [2:0] OFS_BASE_HI  = 3'd1;
    localparam logic [2:0] OFS_STATUS   = 3'd2;
    localparam logic [2:0] OFS_CTRL     = 3'd3;
    localparam logic [2:0] OFS_FADDR_LO = 3'd4;
    localparam logic [2:0] OFS_FADDR_HI = 3'd5;
endpackage

// File: rtl/dpm_map_cache.sv
// One mapping slot per logical page, looked up by page number.
// Assumes flush and fill never need to coexist: flush wins if they do.
module dpm_map_cache #(
    parameter int PAGE_BITS = 4,
    parameter int FRAME_W   = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 fill_we,
    input  logic [PAGE_BITS-1:0] fill_page,
    input  logic [FRAME_W-1:0]   fill_frame,
    input  logic                 fill_wp,
    input  logic                 fill_nx,
    input  logic [PAGE_BITS-1:0] look_page,
    output logic                 hit,
    output logic [FRAME_W-1:0]   frame,
    output logic                 wp,
    output logic                 nx
);
    localparam int SLOTS = 1 << PAGE_BITS;

    logic [SLOTS-1:0]   slot_vld;
    logic [SLOTS-1:0]   slot_wp;
    logic [SLOTS-1:0]   slot_nx;
    logic [FRAME_W-1:0] slot_frame [SLOTS];

    // Valid bits: cleared by reset or flush, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_vld <= '0;
        else if (flush)   slot_vld <= '0;
        else if (fill_we) slot_vld[fill_page] <= 1'b1;
    end

    // Slot payload: written on every fill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            slot_frame[fill_page] <= fill_frame;
            slot_wp[fill_page]    <= fill_wp;
            slot_nx[fill_page]    <= fill_nx;
        end
    end

    // Lookup of the page the CPU is presenting.
    always_comb begin
        hit   = slot_vld[look_page];
        frame = slot_frame[look_page];
        wp    = slot_wp[look_page];
        nx    = slot_nx[look_page];
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_vld == '0)); // R5
    AST_FILL_MAKES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !flush) |=> slot_vld[$past(fill_page)]); // R4
endmodule

// File: rtl/dpm_refill_seq.sv
// Reads one 16-bit table entry as two byte reads, low byte first.
// Assumes the memory acknowledges only while mem_req is high.
module dpm_refill_seq
    import dpm_pkg::*;
#(
    parameter int LA_W      = 16,
    parameter int PAGE_BITS = 4,
    parameter int PA_W      = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAGE_BITS-1:0] start_page,
    input  logic [LA_W-1:0]      tbl_base,
    input  logic                 mem_ack,
    input  logic [7:0]           mem_rdata,
    output logic                 mem_req,
    output logic [PA_W-1:0]      mem_addr,
    output logic                 busy,
    output logic                 done,
    output logic [15:0]          entry,
    output logic [PAGE_BITS-1:0] page
);
    seq_t                 state;
    logic [LA_W-1:0]      addr_q;
    logic [7:0]           lo_q;
    logic [PAGE_BITS-1:0] page_q;

    // Sequencer: idle -> low byte -> high byte -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
            page_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    addr_q <= tbl_base + LA_W'({start_page, 1'b0});
                    page_q <= start_page;
                    state  <= SQ_LO;
                end
                SQ_LO: if (mem_ack) begin
                    lo_q  <= mem_rdata;
                    state <= SQ_HI;
                end
                SQ_HI: if (mem_ack) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Port drive and the completed entry word.
    always_comb begin
        busy     = (state != SQ_IDLE);
        mem_req  = busy;
        mem_addr = PA_W'(addr_q + LA_W'(state == SQ_HI));
        done     = (state == SQ_HI) && mem_ack;
        entry    = {mem_rdata, lo_q};
        page     = page_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !done) |=> (mem_req && $stable(mem_addr))); // R3
    AST_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req)); // R3
endmodule

// File: rtl/dpm_regs.sv
// Register window: table base, fault latch and status read-back.
// Assumes a 16-bit logical address (base and fault address as two bytes).
module dpm_regs
    import dpm_pkg::*;
#(
    parameter int LA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc,
    input  logic            we,
    input  logic [2:0]      ofs,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic [LA_W-1:0] tbl_base,
    output logic            flush,
    input  logic            set_fault,
    input  fault_t          set_type,
    input  logic [LA_W-1:0] set_addr,
    output logic            fault_pend
);
    fault_t          ftype;
    logic [LA_W-1:0] faddr;
    logic            clr;

    // Write decodes for base and fault clear.
    always_comb begin
        flush = acc && we && ((ofs == OFS_BASE_LO) || (ofs == OFS_BASE_HI));
        clr   = acc && we && (ofs == OFS_CTRL) && wdata[0];
    end

    // Table base register bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) tbl_base <= '0;
        else if (acc && we && ofs == OFS_BASE_LO) tbl_base[7:0]  <= wdata;
        else if (acc && we && ofs == OFS_BASE_HI) tbl_base[15:8] <= wdata;
    end

    // Fault latch: set once, held until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_pend <= 1'b0;
            ftype      <= FT_NONE;
            faddr      <= '0;
        end else if (clr) begin
            fault_pend <= 1'b0;
            ftype      <= FT_NONE;
        end else if (set_fault && !fault_pend) begin
            fault_pend <= 1'b1;
            ftype      <= set_type;
            faddr      <= set_addr;
        end
    end

    // Read mux for the window.
    always_comb begin
        case (ofs)
            OFS_BASE_LO:  rdata = tbl_base[7:0];
            OFS_BASE_HI:  rdata = tbl_base[15:8];
            OFS_STATUS:   rdata = {fault_pend, 1'b0, ftype, 4'b0000};
            OFS_FADDR_LO: rdata = faddr[7:0];
            OFS_FADDR_HI: rdata = faddr[15:8];
            default:      rdata = 8'h00;
        endcase
        if (!acc) rdata = 8'h00;
    end

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pend && !clr) |=> fault_pend); // R9
    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fault_pend); // R9
endmodule

// File: rtl/demand_page_mmu.sv
// Top: translates CPU pages through the slot cache, refills on a miss
// by stalling cpu_rdy, and checks write-protect and no-execute.
// Assumes the CPU holds address and access type while cpu_rdy is low.
module demand_page_mmu
    import dpm_pkg::*;
#(
    parameter int          LA_W     = 16,
    parameter int          OFF_W    = 12,
    parameter int          FRAME_W  = 9,
    parameter logic [15:0] WIN_BASE = 16'hFFF8,
    parameter int          WIN_LOG2 = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_valid,
    input  logic [LA_W-1:0]          cpu_addr,
    input  logic                     cpu_we,
    input  logic                     cpu_fetch,
    input  logic [7:0]               cpu_wdata,
    output logic [7:0]               cpu_rdata,
    output logic                     cpu_rdy,
    output logic [FRAME_W+OFF_W-1:0] phys_addr,
    output logic                     fault,
    output logic                     mem_req,
    output logic [FRAME_W+OFF_W-1:0] mem_addr,
    input  logic [7:0]               mem_rdata,
    input  logic                     mem_ack
);
    localparam int PAGE_BITS = LA_W - OFF_W;
    localparam int PA_W      = FRAME_W + OFF_W;

    logic                 in_win, xl_acc, hit, c_wp, c_nx;
    logic                 viol_wp, viol_nx, start, busy, done, flush;
    logic                 ent_ok, set_fault, fault_pend;
    logic [PAGE_BITS-1:0] page, fill_page;
    logic [FRAME_W-1:0]   c_frame;
    logic [15:0]          entry;
    logic [LA_W-1:0]      tbl_base;
    fault_t               set_type;

    // Address classification and rule checks on the cached entry.
    always_comb begin
        in_win  = cpu_addr[LA_W-1:WIN_LOG2] == WIN_BASE[LA_W-1:WIN_LOG2];
        xl_acc  = cpu_valid && !in_win;
        page    = cpu_addr[LA_W-1:OFF_W];
        viol_wp = hit && cpu_we && c_wp;
        viol_nx = hit && cpu_fetch && c_nx;
        start   = xl_acc && !fault_pend && !hit && !busy;
        ent_ok  = entry[ENT_VALID_BIT];
    end

    // Fault source selection.
    always_comb begin
        set_fault = xl_acc && !fault_pend &&
                    ((viol_wp || viol_nx) || (done && !ent_ok));
        if (done && !ent_ok) set_type = FT_UNMAPPED;
        else if (viol_nx)    set_type = FT_NOEXEC;
        else                 set_type = FT_WPROT;
    end

    // CPU-facing outputs.
    always_comb begin
        cpu_rdy   = (cpu_valid && in_win) ||
                    (!fault_pend && (!cpu_valid || (hit && !viol_wp && !viol_nx)));
        phys_addr = in_win ? PA_W'(cpu_addr) : {c_frame, cpu_addr[OFF_W-1:0]};
        fault     = fault_pend;
    end

    dpm_map_cache #(.PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)) u_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_we(done && ent_ok), .fill_page(fill_page),
        .fill_frame(entry[FRAME_W-1:0]), .fill_wp(entry[ENT_WP_BIT]),
        .fill_nx(entry[ENT_NX_BIT]), .look_page(page),
        .hit(hit), .frame(c_frame), .wp(c_wp), .nx(c_nx)
    );

    dpm_refill_seq #(.LA_W(LA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_page(page),
        .tbl_base(tbl_base), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy), .done(done),
        .entry(entry), .page(fill_page)
    );

    dpm_regs #(.LA_W(LA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(cpu_valid && in_win), .we(cpu_we),
        .ofs(cpu_addr[2:0]), .wdata(cpu_wdata), .rdata(cpu_rdata),
        .tbl_base(tbl_base), .flush(flush), .set_fault(set_fault),
        .set_type(set_type), .set_addr(cpu_addr), .fault_pend(fault_pend)
    );

    AST_REFILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(cpu_valid && !in_win && !hit)); // R3
    AST_FAULT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && cpu_valid && !in_win) |=> (fault || !$past(fault))); // R9
endmodule

// File: tb/tb_demand_page_mmu.sv
module tb_demand_page_mmu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0, cpu_fetch = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0, cpu_rdata, mem_rdata;
    logic        cpu_rdy, fault, mem_req, mem_ack;
    logic [20:0] phys_addr, mem_addr;
    logic        ack_en = 1'b1;
    logic [7:0]  tmem [256];

    int checks = 0, errors = 0, rd_cnt = 0;
    logic [20:0] rd_addr [2];
    bit   cached [16];
    logic [7:0] base = 8'h00;
    bit   done_flag = 0;

    always #4 clk = ~clk;

    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = tmem[mem_addr[7:0]];

    demand_page_mmu dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_fetch(cpu_fetch), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy), .phys_addr(phys_addr),
        .fault(fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // Count completed table reads.
    always @(posedge clk) if (mem_req && mem_ack) begin
        if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
        rd_cnt = rd_cnt + 1;
    end

    always @(negedge clk) ack_en <= ($urandom % 4) != 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cpu_valid = 1; cpu_we = 1; cpu_fetch = 0; cpu_addr = 16'hFFF8 | 16'(ofs); cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 0; cpu_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] ofs, output logic [7:0] d);
        @(negedge clk);
        cpu_valid = 1; cpu_we = 0; cpu_fetch = 0; cpu_addr = 16'hFFF8 | 16'(ofs);
        #1;
        d = cpu_rdata;
        chk(cpu_rdy === 1'b1, "R10 window rdy", 32'(cpu_rdy), 1);
        @(negedge clk);
        cpu_valid = 0;
    endtask

    task automatic access(input logic [15:0] a, input bit w, input bit f,
                          output bit first_rdy, output bit faulted, output logic [20:0] pa);
        @(negedge clk);
        cpu_valid = 1; cpu_we = w; cpu_fetch = f; cpu_addr = a;
        rd_cnt = 0; faulted = 0; pa = '0;
        #1;
        first_rdy = cpu_rdy;
        for (int i = 0; i < 60; i++) begin
            if (cpu_rdy) begin pa = phys_addr; break; end
            if (fault) begin faulted = 1; break; end
            @(negedge clk); #1;
        end
        @(negedge clk);
        cpu_valid = 0; cpu_we = 0; cpu_fetch = 0;
    endtask

    function automatic logic [15:0] ent(input bit v, input bit nx, input bit wp, input logic [8:0] fr);
        return {v, nx, wp, 4'b0, fr};
    endfunction

    function automatic logic [15:0] tbl_word(input logic [3:0] p);
        return {tmem[base + 8'(2 * p) + 1], tmem[base + 8'(2 * p)]};
    endfunction

    // Expected fault type: 1 unmapped, 3 no-execute, 2 write-protect, 0 none.
    function automatic logic [1:0] exp_fault(input logic [15:0] e, input bit w, input bit f);
        if (!e[15])        return 2'd1;
        if (f && e[14])    return 2'd3;
        if (w && e[13])    return 2'd2;
        return 2'd0;
    endfunction

    task automatic put_entry(input logic [3:0] p, input logic [15:0] e);
        tmem[base + 8'(2 * p)]     = e[7:0];
        tmem[base + 8'(2 * p) + 1] = e[15:8];
    endtask

    task automatic set_base(input logic [7:0] b);
        base = b;
        reg_wr(3'd0, b);
        reg_wr(3'd1, 8'h00);
        for (int i = 0; i < 16; i++) cached[i] = 0;
    endtask

    // Full checked access against the bench model.
    task automatic run(input logic [15:0] a, input bit w, input bit f, input string tag);
        bit fr, flt; logic [20:0] pa; logic [7:0] st, lo, hi;
        logic [3:0] p; logic [15:0] e; logic [1:0] ft; bit was;
        p = a[15:12]; e = tbl_word(p); ft = exp_fault(e, w, f); was = cached[p];
        access(a, w, f, fr, flt, pa);
        chk(fr == (was && ft == 0), {tag, " R2/R3 first-cycle rdy"}, 32'(fr), 32'(was && ft == 0));
        if (was) chk(rd_cnt == 0, {tag, " R4 no refill reads"}, rd_cnt, 0);
        else begin
            chk(rd_cnt == 2, {tag, " R3 two reads"}, rd_cnt, 2);
            chk(rd_addr[0] == 21'(base + 8'(2 * p)) && rd_addr[1] == 21'(base + 8'(2 * p) + 1),
                {tag, " R3 read addresses"}, 32'(rd_addr[0]), 32'(base + 8'(2 * p)));
        end
        if (e[15]) cached[p] = 1;
        chk(flt == (ft != 0), {tag, " R6/R7/R8 fault raised"}, 32'(flt), 32'(ft != 0));
        if (ft == 0) begin
            chk(pa == {e[8:0], a[11:0]}, {tag, " R2 phys addr"}, 32'(pa), 32'({e[8:0], a[11:0]}));
        end else begin
            reg_rd(3'd2, st);
            chk(st == {1'b1, 1'b0, ft, 4'b0}, {tag, " R9 status"}, 32'(st), 32'({1'b1, 1'b0, ft, 4'b0}));
            reg_rd(3'd4, lo); reg_rd(3'd5, hi);
            chk({hi, lo} == a, {tag, " R9 fault address"}, 32'({hi, lo}), 32'(a));
            reg_wr(3'd3, 8'h01);
            reg_rd(3'd2, st);
            chk(st == 8'h00 && fault == 0, {tag, " R9 cleared"}, 32'(st), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; bit fr, flt; logic [20:0] pa;
        void'($urandom(32'd12345));
        for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
        for (int i = 0; i < 16; i++) cached[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk(cpu_rdy == 1 && fault == 0 && mem_req == 0, "R1 idle outputs", {29'b0, cpu_rdy, fault, mem_req}, 3'b100);
        reg_rd(3'd0, d); chk(d == 0, "R1 base lo", 32'(d), 0);
        reg_rd(3'd1, d); chk(d == 0, "R1 base hi", 32'(d), 0);
        reg_rd(3'd2, d); chk(d == 0, "R1 status", 32'(d), 0);
        chk(rd_cnt == 0, "R10 window starts no reads", rd_cnt, 0);

        // Directed table.
        base = 8'h40;
        put_entry(4'd1, ent(1, 0, 0, 9'h1A5));
        put_entry(4'd2, ent(1, 0, 1, 9'h0F3));
        put_entry(4'd3, ent(1, 1, 0, 9'h101));
        put_entry(4'd4, ent(0, 0, 0, 9'h077));
        set_base(8'h40);
        run(16'h1234, 0, 0, "R3 first touch");
        run(16'h1FFF, 1, 0, "R4 cached hit");
        run(16'h2010, 1, 0, "R6 write protect");
        run(16'h2020, 0, 0, "R6 read of protected");
        run(16'h3000, 0, 1, "R7 no-execute fetch");
        run(16'h3004, 0, 0, "R7 data read of nx");
        run(16'h4444, 0, 0, "R8 unmapped");
        run(16'h4448, 0, 0, "R8 refetch after clear");

        // Pending fault blocks a cached page until cleared.
        access(16'h2100, 1, 0, fr, flt, pa);
        chk(flt == 1, "R9 fault on protected write", 32'(flt), 1);
        access(16'h1000, 0, 0, fr, flt, pa);
        chk(fr == 0 && fault == 1, "R9 stall while pending", 32'(fr), 0);
        reg_wr(3'd3, 8'h00);
        chk(fault == 1, "R9 write without bit0 keeps fault", 32'(fault), 1);
        reg_wr(3'd3, 8'h01);
        run(16'h1008, 0, 0, "R9 resume after clear");

        // Base write invalidates.
        reg_wr(3'd1, 8'h00);
        for (int i = 0; i < 16; i++) cached[i] = 0;
        run(16'h1010, 0, 0, "R5 refill after base write");

        // Random phase.
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a; bit w, f;
            if (k % 40 == 0) begin
                logic [7:0] nb;
                nb = (k % 80 == 0) ? 8'h80 : 8'h40;
                base = nb;
                for (int p = 0; p < 16; p++)
                    put_entry(4'(p), ent(($urandom % 7) != 0, ($urandom % 4) == 0,
                                         ($urandom % 4) == 0, 9'($urandom)));
                set_base(nb);
            end
            a = 16'($urandom);
            if (a[15:3] == 13'h1FFF) a[3] = 1'b0;
            f = ($urandom % 4) == 0;
            w = f ? 1'b0 : 1'($urandom);
            run(a, w, f, "random");
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule